// File: doc/BRIEF.md
# String Load Register Sequencer

This block executes an indexed "load string into registers" instruction for a processor with thirty-two 32-bit general-purpose registers. It decodes the instruction word and reads the base and index registers. It forms the effective address as the index value plus either the base value or zero. It then fetches the requested number of bytes from memory, one byte per request. The bytes are packed into consecutive registers, starting at the destination register.

Bytes enter each register from the most-significant byte down. The register sequence wraps from 31 back to 0, and the low-order bytes of a partially filled final register read as zero. A register in the sequence that matches the base register field is not written unless it is the final register. Its bytes are still fetched. A byte count of zero turns the instruction into a no-op.

The register file and the memory sit outside the block. The sequencer drives two read-address ports and one write port, and uses a request/valid byte-read handshake.

Top module: `strld_seq`

## Requirements
- R1: A start is accepted only while the block is idle and the instruction word has bits [31:26] = 31, bits [10:1] = 533 and bit [0] = 0. Any other start leaves busy low and issues no memory request. The destination field is [25:21], the base field is [20:16] and the index field is [15:11].
- R2: The read-address outputs carry the base and index fields in the cycle after an accepted start, and the register-file data is read combinationally in that cycle. The first memory request uses address (base field = 0 ? 0 : base value) + index value, computed modulo 2^32.
- R3: Byte i of the transfer is requested at the first address plus i, modulo 2^32. Each request is a one-cycle pulse of mem_req_o. The next request is not issued until the previous byte has been returned with mem_valid_i.
- R4: Register k of the transfer holds bytes 4k to 4k+3, with the lowest-numbered byte in bits [31:24], and is written to register (destination + k) mod 32.
- R5: If the count ends partway through the final register, the unfilled low-order bytes of that register are written as zero.
- R6: The register sequence wraps from register 31 to register 0. With ceil(n/4) registers, the final one is (destination + ceil(n/4) − 1) mod 32.
- R7: A register in the sequence equal to the base field is left unwritten unless it is the final register. Its four bytes are still requested, so later addresses are unaffected.
- R8: A byte count of zero issues no memory request and writes no register. It still raises busy and then pulses done.
- R9: busy_o rises in the cycle after an accepted start and stays high until done_o pulses. done_o is high for exactly one cycle, and busy_o is low in that cycle.
- R10: The base and index values are captured when the address is formed. Register writes made during the transfer, including writes to the base or index registers, do not change the address stream.
- R11: A start that arrives while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled with instr_i and byte_cnt_i |
| instr_i | input | 32 | Instruction word |
| byte_cnt_i | input | 7 | Number of bytes to load (0 to 127) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| rf_ra_addr_o | output | 5 | Register-file read address, base register |
| rf_ra_data_i | input | 32 | Register-file read data, base register |
| rf_rb_addr_o | output | 5 | Register-file read address, index register |
| rf_rb_data_i | input | 32 | Register-file read data, index register |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | One-cycle byte read request |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_valid_i | input | 1 | Returned byte is valid |
| mem_data_i | input | 8 | Returned byte |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 7-bit byte count. A count of 127 therefore drives all thirty-two registers in one pass, wraps the sequence and ends one below the destination. Directed cases combine memory latencies of one to three cycles with partial final words, the 31-to-0 wrap and an address that crosses 2^32. They also cover a base register that is skipped in the middle, a base register that is written because it is last, and an index register overwritten mid-transfer.

// File: rtl/strld_pkg.sv
package strld_pkg;
  localparam int REGIDX_W = 5;
  localparam logic [5:0] OPC_MAJOR = 6'd31;
  localparam logic [9:0] OPC_MINOR = 10'd533;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MEM,
    ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic [REGIDX_W-1:0] dst;
    logic [REGIDX_W-1:0] base;
    logic [REGIDX_W-1:0] idx;
  } op_fields_t;
endpackage

// File: rtl/strld_decode.sv
module strld_decode
  import strld_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic        hit_o,
  output op_fields_t  fld_o
);
  // Bit 0 of the word (most significant) sits at [31] here.
  always_comb begin
    hit_o      = (instr_i[31:26] == OPC_MAJOR) &&
                 (instr_i[10:1]  == OPC_MINOR) &&
                 (instr_i[0] == 1'b0);
    fld_o.dst  = instr_i[25:21];
    fld_o.base = instr_i[20:16];
    fld_o.idx  = instr_i[15:11];
  end
endmodule

// File: rtl/strld_addr.sv
module strld_addr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            base_zero_i,
  input  logic [XLEN-1:0] base_val_i,
  input  logic [XLEN-1:0] idx_val_i,
  input  logic            step_i,
  output logic [XLEN-1:0] addr_o
);
  logic [XLEN-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= (base_zero_i ? '0 : base_val_i) + idx_val_i;
    end else if (step_i) begin
      addr_q <= addr_q + XLEN'(1);
    end
  end

  assign addr_o = addr_q;

  // R3: consecutive bytes come from consecutive addresses
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (addr_q == $past(addr_q) + XLEN'(1)));
endmodule

// File: rtl/strld_pack.sv
module strld_pack #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  input  logic            last_i,
  output logic            word_done_o,
  output logic [XLEN-1:0] word_o
);
  localparam int BPW   = XLEN / 8;
  localparam int POS_W = $clog2(BPW);

  logic [POS_W-1:0] pos_q;
  logic [XLEN-1:0]  acc_q;
  logic [XLEN-1:0]  acc_nx;

  // Lane BPW-1 is the most significant byte and is filled first.
  always_comb begin
    acc_nx = acc_q;
    for (int l = 0; l < BPW; l++) begin
      if (pos_q == POS_W'(BPW - 1 - l)) acc_nx[l*8 +: 8] = byte_i;
    end
  end

  assign word_done_o = byte_vld_i && ((pos_q == POS_W'(BPW - 1)) || last_i);
  assign word_o      = acc_nx;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pos_q <= '0;
      acc_q <= '0;
    end else if (byte_vld_i) begin
      if (word_done_o) begin
        pos_q <= '0;
        acc_q <= '0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
        acc_q <= acc_nx;
      end
    end
  end

  // R5: each register starts empty after a word is emitted
  p_acc_clear_r5: assert property (@(posedge clk) disable iff (rst)
    word_done_o |=> (acc_q == '0 && pos_q == '0));
endmodule

// File: rtl/strld_seq.sv
module strld_seq
  import strld_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [31:0]         instr_i,
  input  logic [CNT_W-1:0]    byte_cnt_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [REGIDX_W-1:0] rf_ra_addr_o,
  input  logic [XLEN-1:0]     rf_ra_data_i,
  output logic [REGIDX_W-1:0] rf_rb_addr_o,
  input  logic [XLEN-1:0]     rf_rb_data_i,
  output logic                rf_we_o,
  output logic [REGIDX_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]     rf_wdata_o,
  output logic                mem_req_o,
  output logic [XLEN-1:0]     mem_addr_o,
  input  logic                mem_valid_i,
  input  logic [7:0]          mem_data_i
);
  localparam int BPW   = XLEN / 8;
  localparam int POS_W = $clog2(BPW);
  localparam int CW1   = CNT_W + 1;

  seq_state_e          state_q;
  op_fields_t          dec_fld;
  logic                dec_hit;
  logic                accept;
  logic [CNT_W-1:0]    cnt_q;
  logic [REGIDX_W-1:0] cur_q;
  logic [REGIDX_W-1:0] fin_q;
  logic [REGIDX_W-1:0] base_q;
  logic [CW1-1:0]      nreg_w;
  logic [CW1-1:0]      nreg_m1;
  logic                byte_vld;
  logic                last_byte;
  logic                word_done;
  logic [XLEN-1:0]     word;

  strld_decode u_dec (
    .instr_i (instr_i),
    .hit_o   (dec_hit),
    .fld_o   (dec_fld)
  );

  assign accept    = start_i && dec_hit && (state_q == ST_IDLE);
  assign nreg_w    = ({1'b0, byte_cnt_i} + CW1'(BPW - 1)) >> POS_W;
  assign nreg_m1   = nreg_w - CW1'(1);
  assign byte_vld  = (state_q == ST_MEM) && mem_valid_i;
  assign last_byte = (cnt_q == CNT_W'(1));

  strld_addr #(.XLEN(XLEN)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .load_i      (state_q == ST_ADDR),
    .base_zero_i (base_q == '0),
    .base_val_i  (rf_ra_data_i),
    .idx_val_i   (rf_rb_data_i),
    .step_i      (byte_vld),
    .addr_o      (mem_addr_o)
  );

  strld_pack #(.XLEN(XLEN)) u_pack (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (state_q == ST_ADDR),
    .byte_vld_i  (byte_vld),
    .byte_i      (mem_data_i),
    .last_i      (last_byte),
    .word_done_o (word_done),
    .word_o      (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      cur_q        <= '0;
      fin_q        <= '0;
      base_q       <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      rf_ra_addr_o <= '0;
      rf_rb_addr_o <= '0;
      rf_we_o      <= 1'b0;
      rf_waddr_o   <= '0;
      rf_wdata_o   <= '0;
      mem_req_o    <= 1'b0;
    end else begin
      rf_we_o   <= 1'b0;
      done_o    <= 1'b0;
      mem_req_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cnt_q        <= byte_cnt_i;
            cur_q        <= dec_fld.dst;
            fin_q        <= dec_fld.dst + nreg_m1[REGIDX_W-1:0];
            base_q       <= dec_fld.base;
            rf_ra_addr_o <= dec_fld.base;
            rf_rb_addr_o <= dec_fld.idx;
            busy_o       <= 1'b1;
            state_q      <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (cnt_q == '0) begin
            state_q <= ST_FIN;
          end else begin
            mem_req_o <= 1'b1;
            state_q   <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_valid_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (word_done) begin
              cur_q <= cur_q + REGIDX_W'(1);
              if ((cur_q != base_q) || (cur_q == fin_q)) begin
                rf_we_o    <= 1'b1;
                rf_waddr_o <= cur_q;
                rf_wdata_o <= word;
              end
            end
            if (last_byte) state_q <= ST_FIN;
            else           mem_req_o <= 1'b1;
          end
        end
        default: begin
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R9: done is a single pulse with busy already low
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R3: one request pulse per byte, only while busy
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);
  p_req_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);
  // R4: register writes happen only inside an operation
  p_we_busy_r4: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> busy_o);
  // R7: the base register is written only as the final register
  p_base_skip_r7: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o && rf_waddr_o == base_q) |-> (rf_waddr_o == fin_q));
  // R8: an empty transfer never reaches memory
  p_zero_count_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && cnt_q == '0) |=> (!mem_req_o && !rf_we_o));
endmodule

// File: tb/strld_seq_tb_top.sv
module strld_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [6:0]  byte_cnt = '0;
  logic        busy, done;
  logic [4:0]  ra_addr, rb_addr, waddr;
  logic [31:0] ra_data, rb_data, wdata, maddr;
  logic        we, mreq;
  logic        mvalid = 1'b0;
  logic [7:0]  mdata_q = '0;

  logic [31:0] rf [32];
  logic [31:0] expv [32];
  logic [31:0] req_log [128];
  int          req_cnt = 0;
  int          mem_lat = 1;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          cd = 0;
  logic        overlap = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strld_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start), .instr_i(instr), .byte_cnt_i(byte_cnt),
    .busy_o(busy), .done_o(done),
    .rf_ra_addr_o(ra_addr), .rf_ra_data_i(ra_data),
    .rf_rb_addr_o(rb_addr), .rf_rb_data_i(rb_data),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata),
    .mem_req_o(mreq), .mem_addr_o(maddr), .mem_valid_i(mvalid), .mem_data_i(mdata_q)
  );

  assign ra_data = rf[ra_addr];
  assign rb_data = rf[rb_addr];

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (we) rf[waddr] <= wdata;

  always @(posedge clk) begin
    mvalid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (mreq) begin
      if (pend) overlap <= 1'b1;
      if (req_cnt < 128) req_log[req_cnt] <= maddr;
      req_cnt   <= req_cnt + 1;
      pend      <= 1'b1;
      pend_addr <= maddr;
      cd        <= mem_lat;
    end else if (pend) begin
      if (cd <= 1) begin
        mvalid  <= 1'b1;
        mdata_q <= mem_byte(pend_addr);
        pend    <= 1'b0;
      end else begin
        cd <= cd - 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  // One transfer: preload, run, compare registers and address stream.
  task automatic run_case(input string tag, input logic [4:0] rd, input logic [4:0] ra,
                          input logic [4:0] rb, input logic [31:0] va, input logic [31:0] vb,
                          input logic [6:0] n, input int lat, input bit poke);
    logic [31:0] ea;
    int nr, fin, waitc;
    bit seen;
    @(negedge clk);
    for (int i = 0; i < 32; i++) rf[i] = (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0000;
    rf[ra] = va;
    rf[rb] = vb;
    for (int i = 0; i < 32; i++) expv[i] = rf[i];
    ea = ((ra == 5'd0) ? 32'd0 : va) + vb;
    nr  = (int'(n) + 3) / 4;
    fin = (int'(rd) + nr - 1) % 32;
    for (int k = 0; k < nr; k++) begin
      int r;
      logic [31:0] w;
      r = (int'(rd) + k) % 32;
      w = '0;
      for (int b = 0; b < 4; b++)
        if (4*k + b < int'(n)) w[31-8*b -: 8] = mem_byte(ea + 32'(4*k + b));
      if (r != int'(ra) || r == fin) expv[r] = w;
    end
    req_cnt = 0;
    overlap = 1'b0;
    mem_lat = lat;
    instr = {6'd31, rd, ra, rb, 10'd533, 1'b0};
    byte_cnt = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R9"}, "busy after start", 32'(busy), 32'd1);
    if (poke) begin
      instr = {6'd31, 5'd25, 5'd26, 5'd27, 10'd533, 1'b0};
      byte_cnt = 7'd4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    waitc = 0;
    while (!seen && waitc < 3000) begin
      if (done) seen = 1'b1;
      else begin @(negedge clk); waitc++; end
    end
    chk({tag, " R9"}, "done seen", 32'(seen), 32'd1);
    chk({tag, " R9"}, "busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk({tag, " R9"}, "done one cycle", 32'(done), 32'd0);
    chk({tag, " R3"}, "request count", 32'(req_cnt), 32'(n));
    chk({tag, " R3"}, "one outstanding", 32'(overlap), 32'd0);
    for (int i = 0; i < int'(n); i++)
      chk({tag, " R2/R3/R10"}, $sformatf("address of byte %0d", i), req_log[i], ea + 32'(i));
    for (int i = 0; i < 32; i++)
      chk({tag, " R4"}, $sformatf("register %0d", i), rf[i], expv[i]);
  endtask

  // Instruction words that do not match must be ignored.
  task automatic bad_opcode();
    @(negedge clk);
    req_cnt = 0;
    instr = {6'd31, 5'd2, 5'd3, 5'd4, 10'd534, 1'b0};
    byte_cnt = 7'd8;
    start = 1'b1;
    @(negedge clk);
    instr = {6'd30, 5'd2, 5'd3, 5'd4, 10'd533, 1'b0};
    @(negedge clk);
    instr = {6'd31, 5'd2, 5'd3, 5'd4, 10'd533, 1'b1};
    @(negedge clk);
    start = 1'b0;
    chk("R1", "busy after bad start", 32'(busy), 32'd0);
    repeat (4) @(negedge clk);
    chk("R1", "requests after bad start", 32'(req_cnt), 32'd0);
    chk("R1", "done after bad start", 32'(done), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset", "busy", 32'(busy), 32'd0);
    chk("reset", "done", 32'(done), 32'd0);
    chk("reset", "mem_req", 32'(mreq), 32'd0);
    chk("reset", "rf_we", 32'(we), 32'd0);
    // R2: base field 0 uses zero even though register 0 is nonzero
    run_case("R2 zero-base", 5'd4, 5'd0, 5'd2, 32'hDEAD_0000, 32'h0000_0100, 7'd8, 1, 1'b0);
    // R5: 7 bytes leave one low byte zero in the second register
    run_case("R5 partial", 5'd12, 5'd3, 5'd9, 32'h0000_2000, 32'h0000_0035, 7'd7, 2, 1'b0);
    // R6: 30, 31, 0 with a 2-byte tail
    run_case("R6 wrap", 5'd30, 5'd5, 5'd6, 32'h0001_0000, 32'h0000_0011, 7'd10, 3, 1'b0);
    // R7 middle skip, R10 index overwritten, R11 start while busy
    run_case("R7 R10 R11 skip", 5'd5, 5'd7, 5'd6, 32'h0000_4000, 32'h0000_0010, 7'd16, 2, 1'b1);
    // R7: base register is final, so it is written
    run_case("R7 last", 5'd10, 5'd11, 5'd1, 32'h0000_0300, 32'h0000_0007, 7'd6, 1, 1'b0);
    // R2: address sum and increments wrap past 2^32
    run_case("R2 addr-wrap", 5'd20, 5'd9, 5'd12, 32'hFFFF_FFFC, 32'h0000_0002, 7'd4, 1, 1'b0);
    // R8: empty transfer
    run_case("R8 zero", 5'd3, 5'd4, 5'd5, 32'h0000_1000, 32'h0000_0020, 7'd0, 1, 1'b0);
    // R6: maximum count covers every register
    run_case("R6 R7 full", 5'd1, 5'd20, 5'd21, 32'h0000_8000, 32'h0000_0044, 7'd127, 1, 1'b0);
    bad_opcode();
    finish_run();
  end
endmodule